// File: doc/BRIEF.md
# Multiply-Accumulate Rounding Shift Unit

This unit is one registered integer datapath stage. It multiplies two XLEN-bit operands and keeps the low XLEN bits of the product. It then either adds that product to an accumulator operand or subtracts it from the accumulator. A non-zero shift immediate makes it round half up and shift right arithmetically. It is meant for the two-coefficient butterfly steps of fixed-point transforms: a shared accumulator gets one more weighted term, and the result is scaled back down in the same stage.

A 5-bit operation code selects what the stage does:

- `5'b01001` adds the product to the accumulator.
- `5'b01010` subtracts the product from the accumulator.
- Any other code leaves the output register unchanged.

The result appears on `result_o` one clock after the inputs are presented. The unit has no status or flag outputs.

Top module: `mac_round_shift`

## Requirements
- R1: While `rst_n` is low, `result_o` is cleared to zero on each rising clock edge.
- R2: With `op_i` = 5'b01001, the intermediate value is `acc_i` plus the low XLEN bits of `src_a_i`·`src_b_i`. The product is the same for signed and unsigned reading of the operands, because only the low half is kept. All arithmetic wraps modulo 2^XLEN.
- R3: With `op_i` = 5'b01010, the intermediate value is `acc_i` minus that product, with the product taken from the accumulator.
- R4: When `shamt_i` is 0, `result_o` equals the raw intermediate value, with no rounding and no shift.
- R5: When `shamt_i` = n > 0, the unit adds 2^(n-1) to the intermediate value, wrapping. It then shifts the wrapped sum right by n arithmetically. This rounds half up, so 3>>1 gives 2 and -3>>1 gives -1.
- R6: The n vacated upper bits are copies of the sign bit of the rounded, wrapped value. For example, 0x7FFF_FFFF_FFFF_FFFF with n=1 gives 0xC000_0000_0000_0000.
- R7: For any other `op_i` code, `result_o` keeps its previous value.
- R8: `result_o` reflects the inputs sampled at the previous rising clock edge, with a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_i | input | XLEN | Accumulator operand |
| src_a_i | input | XLEN | First multiplicand |
| src_b_i | input | XLEN | Second multiplicand |
| shamt_i | input | SHW | Rounding shift amount n |
| op_i | input | OPW | Operation code (01001 add, 01010 subtract) |
| result_o | output | XLEN | Registered new accumulator value |

## Verification
The hardest case to reach is the rounding carry that wraps a large positive sum into a negative number, which then sign-fills the whole upper field. Random operands almost never land within 2^(n-1) of the positive limit. Directed vectors therefore set the accumulator to the maximum positive value with a zero product, and also exercise exact half-way values of both signs. A random sweep then steps through every shift amount from 0 to 31 in both modes, interleaved with idle codes.

// File: rtl/mac_round_shift.sv
module mac_round_shift #(
  parameter int XLEN = 64,
  parameter int SHW  = 5,
  parameter int OPW  = 5,
  parameter logic [OPW-1:0] OP_ADD = 5'b01001,
  parameter logic [OPW-1:0] OP_SUB = 5'b01010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] acc_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  input  logic [SHW-1:0]  shamt_i,
  input  logic [OPW-1:0]  op_i,
  output logic [XLEN-1:0] result_o
);
  localparam logic [XLEN-1:0] ONES = {XLEN{1'b1}};

  logic [XLEN-1:0] prod_lo, inter, rounded, rotated, keep_mask, shifted;
  logic [31:0]     rot_amt;
  logic            sign_fill, is_add, is_sub;

  assign is_add  = (op_i == OP_ADD);
  assign is_sub  = (op_i == OP_SUB);
  assign prod_lo = src_a_i * src_b_i;
  assign inter   = is_sub ? (acc_i - prod_lo) : (acc_i + prod_lo);

  assign rounded   = inter + (XLEN'(1) << (shamt_i - SHW'(1)));
  assign sign_fill = rounded[XLEN-1];
  assign rot_amt   = 32'(XLEN) - 32'(shamt_i);
  assign rotated   = (rounded << rot_amt) | (rounded >> shamt_i);
  assign keep_mask = ONES >> shamt_i;
  assign shifted   = (rotated & keep_mask) | ({XLEN{sign_fill}} & ~keep_mask);

  always_ff @(posedge clk) begin
    if (!rst_n)
      result_o <= '0;
    else if (is_add || is_sub)
      result_o <= (shamt_i == '0) ? inter : shifted;
  end
endmodule

// File: rtl/mac_round_shift_chk.sv
module mac_round_shift_chk #(
  parameter int XLEN = 64,
  parameter int SHW  = 5,
  parameter int OPW  = 5,
  parameter logic [OPW-1:0] OP_ADD = 5'b01001,
  parameter logic [OPW-1:0] OP_SUB = 5'b01010
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] acc_i,
  input logic [XLEN-1:0] src_a_i,
  input logic [XLEN-1:0] src_b_i,
  input logic [SHW-1:0]  shamt_i,
  input logic [OPW-1:0]  op_i,
  input logic [XLEN-1:0] result_o
);
  logic active;
  assign active = (op_i == OP_ADD) || (op_i == OP_SUB);

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && $past(rst_n)) |=> $stable(result_o));

  a_r2_add_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADD && shamt_i == '0) |=>
      result_o == $past(acc_i) + $past(src_a_i) * $past(src_b_i));

  a_r3_sub_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SUB && shamt_i == '0) |=>
      result_o == $past(acc_i) - $past(src_a_i) * $past(src_b_i));

  a_r6_sign_field: assert property (@(posedge clk) disable iff (!rst_n)
    (active && shamt_i != '0) |=>
      (((result_o ^ {XLEN{result_o[XLEN-1]}}) &
        ~({XLEN{1'b1}} >> ($past(shamt_i) + 1'b1))) == '0));
endmodule

bind mac_round_shift mac_round_shift_chk #(
  .XLEN(XLEN), .SHW(SHW), .OPW(OPW), .OP_ADD(OP_ADD), .OP_SUB(OP_SUB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .src_a_i(src_a_i),
  .src_b_i(src_b_i), .shamt_i(shamt_i), .op_i(op_i), .result_o(result_o)
);

// File: tb/mac_round_shift_tb.sv
`timescale 1ns/1ps
module mac_round_shift_tb;
  localparam logic [4:0] ADD = 5'b01001, SUB = 5'b01010;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] acc, sa, sb, result;
  logic [4:0]  sh, op;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mac_round_shift u_dut (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .src_a_i(sa), .src_b_i(sb),
    .shamt_i(sh), .op_i(op), .result_o(result)
  );

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] x,
                                        logic [63:0] y, int n, logic sub);
    logic [63:0] p, s;
    p = x * y;
    s = sub ? a - p : a + p;
    if (n == 0) return s;
    s = s + (64'd1 << (n - 1));
    return 64'($signed(s) >>> n);
  endfunction

  task automatic check(string req, logic [63:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, result, exp);
    end
  endtask

  task automatic apply(logic [4:0] o, logic [63:0] a, logic [63:0] x,
                       logic [63:0] y, logic [4:0] n);
    op = o; acc = a; sa = x; sb = y; sh = n;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] prev;
    rst_n = 1'b0; op = ADD; acc = 64'h55; sa = 3; sb = 7; sh = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", 64'h0);
    rst_n = 1'b1;

    apply(ADD, 64'h100, 64'd3, 64'd5, 5'd0);
    check("R2 R8 add raw", 64'h10F);
    apply(SUB, 64'h100, 64'd3, 64'd5, 5'd0);
    check("R3 sub raw", 64'hF1);
    apply(ADD, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 5'd0);
    check("R2 R4 signed product", 64'd3);
    apply(ADD, 64'd3, 64'd0, 64'd0, 5'd1);
    check("R5 half up positive", 64'd2);
    apply(ADD, 64'hFFFF_FFFF_FFFF_FFFD, 64'd0, 64'd0, 5'd1);
    check("R5 half up negative", 64'hFFFF_FFFF_FFFF_FFFF);
    apply(SUB, 64'd0, 64'd5, 64'd1, 5'd1);
    check("R3 R5 sub round", 64'hFFFF_FFFF_FFFF_FFFE);
    apply(ADD, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 64'd0, 5'd1);
    check("R6 wrap sign fill", 64'hC000_0000_0000_0000);
    apply(ADD, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 64'd0, 5'd31);
    check("R6 wrap n31", 64'hFFFF_FFFF_0000_0000);
    apply(ADD, 64'h4000_0000, 64'd0, 64'd0, 5'd31);
    check("R5 n31 half", 64'd1);
    prev = result;
    apply(5'b01011, 64'h1234, 64'd9, 64'd9, 5'd3);
    check("R7 idle code holds", prev);
    apply(5'b00000, 64'h0, 64'd1, 64'd1, 5'd0);
    check("R7 zero code holds", prev);

    for (int i = 0; i < 4000; i++) begin
      logic [63:0] a, x, y;
      logic [4:0]  o, n;
      logic [31:0] r;
      a = {$urandom, $urandom}; x = {$urandom, $urandom}; y = {$urandom, $urandom};
      n = 5'(i % 32);
      r = $urandom % 8;
      o = (r < 3) ? ADD : (r < 6) ? SUB : 5'($urandom);
      prev = result;
      apply(o, a, x, y, n);
      if (o == ADD)      check("R2 R5 random add", model(a, x, y, n, 1'b0));
      else if (o == SUB) check("R3 R5 random sub", model(a, x, y, n, 1'b1));
      else               check("R7 random idle", prev);
    end

    rst_n = 1'b0;
    apply(ADD, 64'h77, 64'd1, 64'd1, 5'd0);
    check("R1 reset clears", 64'h0);
    finish_run();
  end

  initial void'($urandom(32'd1234));
endmodule